// File: doc/BRIEF.md
# ADC Serial Result Output Port

This block sends a stored 16-bit conversion result out of one serial data pin, most significant bit first. It has two clocking modes. In master mode it makes its own serial clock from the system clock and drives a frame sync around each word. In slave mode an external host supplies the serial clock, framed by an active-low chip select. In that mode a serial input lets several converters share one data line as a daisy chain. Strap inputs select the clock source, the active clock edge, the sync polarity, the number format, the read timing and the master clock divider.

The control is one state machine with three states. `ST_IDLE` waits. `ST_MSEND` sends one master word. `ST_SFRAME` follows a slave frame. The transitions are:
- *master start*, `ST_IDLE` to `ST_MSEND`: in master mode, on the strobe chosen by the read mode.
- *word complete*, `ST_MSEND` to `ST_IDLE`: at the end of the 16th bit period.
- *select*, `ST_IDLE` to `ST_SFRAME`: in slave mode, when the synchronized chip select goes active.
- *deselect*, `ST_SFRAME` to `ST_IDLE`: when chip select goes inactive or slave mode is left.

The shift register is loaded on each transition out of `ST_IDLE`.

The slave clock, chip select and serial input are brought into the system clock domain through a synchronizer. The host therefore has to hold each level for several system clock cycles.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, with no frame in progress, `sclk_out` rests at its idle level (equal to `sclk_inv`). `sync_out` is at its inactive level (equal to `sync_inv`). `sdo_oe` is high in master mode.
- R2: Master read-after mode (`slave_sel`=0, `rd_during`=0): a `conv_done` pulse starts a frame that sends `conv_result` MSB first. The active edge is the one that takes `sclk_out` away from its idle level. `sdo` changes only when `sclk_out` returns to idle, so it stays constant through each whole bit period.
- R3: In master read-after mode, `div_sel` code k (0 to 3) makes each bit period 2^(k+1) system clock cycles. The sync is active for exactly 16 bit periods.
- R4: Master read-during mode (`rd_during`=1): a `conv_start` pulse sends the result captured by the most recent earlier `conv_done`. `conv_done` alone starts no frame. `div_sel` is ignored and the bit period is 2 cycles.
- R5: With `fmt_twos`=1 the MSB of the word is inverted when the word is loaded, which turns offset binary into two's complement. With `fmt_twos`=0 the word is sent unchanged.
- R6: With `sync_inv`=0 the master sync is active high. With `sync_inv`=1 it is active low.
- R7: With `sclk_inv`=0 the active edge is rising. With `sclk_inv`=1 it is falling. This holds in both master and slave modes.
- R8: Slave mode (`slave_sel`=1): while `cs_n` is low, `sdo_oe` is high. The word latched by the last `conv_done` is shown MSB first, and `sdo` advances one bit on each active edge of `sclk_in`.
- R9: In slave mode, the level on `sdin` at each active edge enters the shift register. It appears on `sdo` 16 active edges later.
- R10: In slave mode, while `cs_n` is high, `sdo_oe` is low. A frame cut short and then restarted sends again from the MSB. A `conv_done` during a frame does not change that frame; the new word is loaded only at the next frame start.
- R11: In master mode, `sclk_out` moves away from its idle level only while the sync is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Conversion start strobe; starts a frame in read-during mode |
| conv_done | input | 1 | Conversion done strobe; qualifies `conv_result` |
| conv_result | input | 16 | Offset-binary conversion result |
| slave_sel | input | 1 | 0 = master clocking, 1 = slave clocking |
| rd_during | input | 1 | Master read timing: 0 = after conversion, 1 = during the next conversion |
| fmt_twos | input | 1 | 1 = two's complement output, 0 = offset binary |
| sync_inv | input | 1 | 1 = active-low master sync |
| sclk_inv | input | 1 | 1 = falling active edge |
| div_sel | input | 2 | Master clock divide code (read-after mode only) |
| sclk_in | input | 1 | External serial clock (slave mode) |
| cs_n | input | 1 | Active-low chip select (slave mode) |
| sdin | input | 1 | Daisy-chain serial input (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sync_out | output | 1 | Master frame sync |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Data output enable |

## Verification
The bench checks frame length at the extreme divide codes. A divider that ignored `div_sel`, or did not drop it in read-during mode, would produce a sync pulse of the wrong length. It checks that read-during sends the previous word. A design that loaded the fresh word, or started a frame on `conv_done`, would send the wrong data or an extra frame. In slave mode it runs 32 edges to check that the daisy-chain input returns exactly 16 edges late. It also pulses `conv_done` in the middle of a frame to catch a design that reloads the word during a frame. Finally it cuts a frame short after five edges and then restarts it, to catch a shift position that survives deselect.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MSEND  = 2'd1,
        ST_SFRAME = 2'd2
    } port_state_t;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/adc_sp_clkgen.sv
module adc_sp_clkgen #(
    parameter int DIVW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            phase,
    output logic            bit_end
);
    localparam int CW = (1 << DIVW) - 1;

    logic [CW-1:0] cnt;
    logic [CW:0]   half;
    logic          last_half;

    assign half      = (CW+1)'(1) << div;
    assign last_half = ({1'b0, cnt} == half - 1'b1);
    assign bit_end   = en & phase & last_half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (last_half) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R11: the clock phase is parked whenever no word is being sent
    a_r11_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !phase);
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         din,
    output logic         dout
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shreg <= '0;
        else if (load)  shreg <= load_val;
        else if (shift) shreg <= {shreg[W-2:0], din};
    end

    assign dout = shreg[W-1];

    // R9: each shift takes in the chain input bit
    a_r9_chain_in: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (shreg[0] == $past(din)));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int DIVW        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_result,
    input  logic              slave_sel,
    input  logic              rd_during,
    input  logic              fmt_twos,
    input  logic              sync_inv,
    input  logic              sclk_inv,
    input  logic [DIVW-1:0]   div_sel,
    input  logic              sclk_in,
    input  logic              cs_n,
    input  logic              sdin,
    output logic              sclk_out,
    output logic              sync_out,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int BCW = $clog2(WORD_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);

    port_state_t       state, state_nxt;
    logic [BCW-1:0]    bit_cnt;
    logic [WORD_W-1:0] held;
    logic [WORD_W-1:0] raw_word, load_word;
    logic [DIVW-1:0]   div_eff;
    logic              phase, bit_end;
    logic              sclk_s, sclk_d, cs_s, sdin_s;
    logic              cs_act, slv_edge, master_go;
    logic              load, shift;

    adc_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sclk_s));
    adc_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
    adc_sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d(sdin), .q(sdin_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign cs_act   = ~cs_s;
    assign slv_edge = sclk_inv ? (sclk_d & ~sclk_s) : (sclk_s & ~sclk_d);
    assign master_go = ~slave_sel & (rd_during ? conv_start : conv_done);
    assign div_eff  = rd_during ? '0 : div_sel;

    // latest result, sent later in read-during and slave modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         held <= '0;
        else if (conv_done) held <= conv_result;
    end

    assign raw_word  = (slave_sel || rd_during) ? held : conv_result;
    assign load_word = fmt_twos ? {~raw_word[WORD_W-1], raw_word[WORD_W-2:0]}
                                : raw_word;

    adc_sp_clkgen #(.DIVW(DIVW)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(state == ST_MSEND), .div(div_eff),
        .phase(phase), .bit_end(bit_end));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (slave_sel && cs_act) state_nxt = ST_SFRAME;
                else if (master_go)      state_nxt = ST_MSEND;
            end
            ST_MSEND: begin
                if (bit_end && bit_cnt == LAST_BIT) state_nxt = ST_IDLE;
            end
            ST_SFRAME: begin
                if (!slave_sel || !cs_act) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase

        load     = (state == ST_IDLE) && (state_nxt != ST_IDLE);
        shift    = ((state == ST_MSEND) && bit_end) ||
                   ((state == ST_SFRAME) && slv_edge);
        sclk_out = ((state == ST_MSEND) & phase) ^ sclk_inv;
        sync_out = (state == ST_MSEND) ^ sync_inv;
        sdo_oe   = slave_sel ? (state == ST_SFRAME) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            bit_cnt <= '0;
        else if (load)                         bit_cnt <= '0;
        else if (state == ST_MSEND && bit_end) bit_cnt <= bit_cnt + 1'b1;
    end

    adc_sp_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_word),
        .shift(shift), .din(slave_sel & sdin_s), .dout(sdo));

    // R2: master data holds for the whole bit period
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MSEND && !bit_end) |=> $stable(sdo));

    // R3: a master frame ends only after the last of its bits
    a_r3_word_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_MSEND) |-> ($past(bit_cnt) == LAST_BIT));

    // R10: deselect turns the slave output driver off
    a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_sel && !cs_act) |=> (!sdo_oe || !slave_sel));
endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int CLK_P = 10;
    localparam int SH    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0, conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic        slave_sel = 1'b0, rd_during = 1'b0, fmt_twos = 1'b0;
    logic        sync_inv = 1'b0, sclk_inv = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        sclk_in = 1'b0, cs_n = 1'b1, sdin = 1'b0;
    logic        sclk_out, sync_out, sdo, sdo_oe;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    int    exp_half = 1;
    string cur_req = "R2";
    int    stray = 0;
    bit    done_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_serial_port uut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .slave_sel(slave_sel), .rd_during(rd_during),
        .fmt_twos(fmt_twos), .sync_inv(sync_inv), .sclk_inv(sclk_inv),
        .div_sel(div_sel), .sclk_in(sclk_in), .cs_n(cs_n), .sdin(sdin),
        .sclk_out(sclk_out), .sync_out(sync_out), .sdo(sdo), .sdo_oe(sdo_oe));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // master monitor: captures bits at the active edge, scores at frame end
    logic        in_frame = 1'b0, prev_sclk = 1'b0;
    logic [15:0] cap = '0;
    int          nbits = 0, sync_cyc = 0;
    always @(negedge clk) begin
        if (rst_n && !slave_sel) begin
            if (sync_out != sync_inv) begin
                if (!in_frame) begin nbits = 0; sync_cyc = 0; cap = '0; end
                sync_cyc++;
                if (sclk_out != prev_sclk && sclk_out != sclk_inv) begin
                    cap = {cap[14:0], sdo};
                    nbits++;
                end
                in_frame = 1'b1;
            end else begin
                if (sclk_out != sclk_inv) stray++;
                if (in_frame) begin
                    if (exp_q.size() == 0) check({cur_req, " unexpected frame"}, 32'(cap), 32'hFFFF_FFFF);
                    else check({cur_req, " word"}, 32'(cap), 32'(exp_q.pop_front()));
                    check({cur_req, " bits"}, 32'(nbits), 32'd16);
                    check({cur_req, " sync length"}, 32'(sync_cyc), 32'(32 * exp_half));
                end
                in_frame = 1'b0;
            end
        end
        prev_sclk = sclk_out;
    end

    task automatic pulse_done(input logic [15:0] v);
        conv_result = v; conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
    endtask

    task automatic m_frame(input string req, input logic [15:0] v,
                           input logic [15:0] e, input int half);
        cur_req = req; exp_half = half;
        exp_q.push_back(e);
        pulse_done(v);
        tick(32 * half + 8);
    endtask

    task automatic m_start(input string req, input logic [15:0] e);
        cur_req = req; exp_half = 1;
        exp_q.push_back(e);
        conv_start = 1'b1;
        tick(1);
        conv_start = 1'b0;
        tick(40);
    endtask

    // slave: sample before each active edge, drive chain bit, toggle clock
    task automatic slave_bits(input int n, input logic [15:0] pat, input int done_at,
                              input logic [15:0] done_val, output logic [15:0] got);
        got = '0;
        for (int k = 0; k < n; k++) begin
            if (k == done_at) pulse_done(done_val);
            @(negedge clk);
            got = {got[14:0], sdo};
            tick(1);
            sdin = pat[15-k];
            tick(SH);
            sclk_in = ~sclk_inv;
            tick(SH);
            sclk_in = sclk_inv;
            tick(SH);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        @(negedge clk);
        check("R1 idle sclk", 32'(sclk_out), 32'd0);
        check("R1 idle sync", 32'(sync_out), 32'd0);
        check("R1 oe master", 32'(sdo_oe), 32'd1);
        tick(1);

        m_frame("R2", 16'hA5C3, 16'hA5C3, 1);
        div_sel = 2'd3;
        m_frame("R3", 16'h1234, 16'h1234, 8);
        div_sel = 2'd1; fmt_twos = 1'b1;
        m_frame("R5", 16'h8001, 16'h0001, 2);
        fmt_twos = 1'b0; sync_inv = 1'b1; sclk_inv = 1'b1; div_sel = 2'd2;
        tick(2);
        @(negedge clk);
        check("R7 idle sclk inverted", 32'(sclk_out), 32'd1);
        check("R6 idle sync active-low", 32'(sync_out), 32'd1);
        tick(1);
        m_frame("R6", 16'h5A0F, 16'h5A0F, 4);

        rd_during = 1'b1; div_sel = 2'd3;
        m_start("R4", 16'h5A0F);
        pulse_done(16'hC0DE);
        tick(40);
        @(negedge clk);
        check("R4 no frame on done", 32'(sync_out), 32'(sync_inv));
        tick(1);
        m_start("R4", 16'hC0DE);
        check("R11 stray sclk", 32'(stray), 32'd0);
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);

        // slave mode
        rd_during = 1'b0; sync_inv = 1'b0; sclk_inv = 1'b0; sclk_in = 1'b0;
        slave_sel = 1'b1;
        tick(6);
        check("R10 oe off deselected", 32'(sdo_oe), 32'd0);
        pulse_done(16'h3C96);
        cs_n = 1'b0;
        tick(SH);
        check("R8 oe on selected", 32'(sdo_oe), 32'd1);
        slave_bits(16, 16'hB1E7, 4, 16'h7777, got);
        check("R8 R10 slave word kept", 32'(got), 32'h3C96);
        slave_bits(16, 16'h0000, -1, 16'h0000, got);
        check("R9 daisy chain", 32'(got), 32'hB1E7);
        cs_n = 1'b1;
        tick(SH);
        check("R10 oe off after frame", 32'(sdo_oe), 32'd0);

        sclk_inv = 1'b1; sclk_in = 1'b1; fmt_twos = 1'b1;
        tick(SH);
        cs_n = 1'b0;
        tick(SH);
        slave_bits(16, 16'h0000, -1, 16'h0000, got);
        check("R7 R5 slave falling edge", 32'(got), 32'hF777);
        cs_n = 1'b1;
        tick(SH);

        cs_n = 1'b0;
        tick(SH);
        slave_bits(5, 16'h0000, -1, 16'h0000, got);
        check("R10 partial bits", 32'(got), 32'h001E);
        cs_n = 1'b1;
        tick(SH);
        check("R10 oe off after abort", 32'(sdo_oe), 32'd0);
        cs_n = 1'b0;
        tick(SH);
        slave_bits(16, 16'h0000, -1, 16'h0000, got);
        check("R10 restart from MSB", 32'(got), 32'hF777);
        cs_n = 1'b1;
        tick(SH);
        finish_run();
    end
endmodule